// File: doc/BRIEF.md
# Wiper Position Store Sequencer

This block decides when the present tap position of a push-button potentiometer is committed to its non-volatile register. It holds a behavioural model of that register. The model is a storage word with a fixed busy window after each write. In the first clock after reset, the block does three things. It samples an active-low store-enable pin to pick the operating mode. It latches that pin's level into its debounce filter. It sends the stored tap back to the position counter as a one-cycle recall strobe.

In automatic mode, a write happens after a long stretch with no button activity. The write is skipped when the tap already matches the stored word. In manual mode, the store-enable pin acts as a store push button. A held-low press ends in one write when the pin is released. While the pin is held low, wiper movement is locked out. The freeze output tells the button controller to stop moving the wiper. It is high during the lock and for the whole write.

The write strobe (`wr_valid` with `wr_data`) and the recall strobe (`recall_valid` with `recall_tap`) are valid-only streams with no ready input. There is no back-pressure, so the sink must accept each beat in the cycle it is shown. Two writes are always at least one busy window apart.

Top module: `nvs_store_seq`

## Requirements
- R1: Mode is chosen once, in the first clock after reset. `store_en_n` low selects automatic mode. High selects manual mode, and in manual mode idle time alone never causes a write.
- R2: In the first clock after reset, `recall_valid` is high for exactly one cycle. `recall_tap` carries the stored word, which after reset is mid-scale (`1 << (TAP_W-1)`, 8 for 4 bits).
- R3: In automatic mode, a write of `tap_in` is issued once `IDLE_MS` ticks (default 2000) pass with `btn_active` low. Any activity restarts this count.
- R4: In automatic mode, no write is issued when `tap_in` equals the stored word.
- R5: In automatic mode, at most one write is issued per idle stretch. A further write needs new button activity first.
- R6: In manual mode, the pin must be held low for at least `DEB_MS` ticks (default 15). It must then stay high for `DEB_MS` ticks. This issues exactly one write of `tap_in`. A shorter low pulse causes no write.
- R7: In manual mode, `freeze` is high from the moment the filtered pin level goes low until it returns high.
- R8: `wr_valid` is a single-cycle pulse. `freeze` stays high for `BUSY_MS` ticks (default 20) after each write. Button activity and pin edges that arrive during this window are discarded and cause no later write.
- R9: In automatic mode, toggling `store_en_n` causes neither a write nor `freeze`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| store_en_n | input | 1 | Active-low store-enable / store button pin |
| btn_active | input | 1 | High while either wiper button is pressed |
| tap_in | input | TAP_W | Present wiper tap |
| wr_valid | output | 1 | One-cycle write strobe to the non-volatile register |
| wr_data | output | TAP_W | Tap value written with `wr_valid` |
| recall_valid | output | 1 | One-cycle strobe loading the position counter |
| recall_tap | output | TAP_W | Recalled tap value |
| freeze | output | 1 | Blocks wiper movement (write busy or manual lock) |

## Verification
Some properties are checked on every cycle. Each write pulse lasts one cycle. It never starts inside a busy window, and `freeze` follows it. In automatic mode, a written value always differs from the stored word. The recall strobe never lasts beyond one cycle. Other behaviour can only be shown by the bench's scenarios: the length of the debounce and idle windows, the restart of the idle count on activity, the manual-mode lock, and the discarding of inputs during a write. Each of these depends on a sequence of stimulus that spans thousands of ticks.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [0:0] {
    MODE_MANUAL = 1'b0,
    MODE_AUTO   = 1'b1
  } nvs_mode_e;
endpackage

// File: rtl/nvs_debounce.sv
module nvs_debounce #(
  parameter int DEB_TICKS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_val,
  input  logic tick,
  input  logic raw,
  output logic level,
  output logic rise
);
  localparam int CW = $clog2(DEB_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

  logic          sync1, sync2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
      level <= 1'b1;
      cnt   <= '0;
      rise  <= 1'b0;
    end else if (load) begin
      sync1 <= load_val;
      sync2 <= load_val;
      level <= load_val;
      cnt   <= '0;
      rise  <= 1'b0;
    end else begin
      sync1 <= raw;
      sync2 <= sync1;
      rise  <= 1'b0;
      if (sync2 == level) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == LAST) begin
          level <= sync2;
          rise  <= sync2;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nvs_idle_timer.sv
module nvs_idle_timer #(
  parameter int IDLE_TICKS = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic tick,
  input  logic activity,
  output logic fire
);
  localparam int CW = $clog2(IDLE_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_TICKS - 1);
  localparam logic [CW-1:0] FULL = CW'(IDLE_TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      fire <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (!hold) begin
        if (activity) begin
          cnt <= '0;
        end else if (tick && cnt != FULL) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) fire <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nvs_cell.sv
module nvs_cell #(
  parameter int TAP_W      = 4,
  parameter int BUSY_TICKS = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [TAP_W-1:0] wr_data,
  output logic [TAP_W-1:0] q,
  output logic             busy
);
  localparam int CW = $clog2(BUSY_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(BUSY_TICKS - 1);
  localparam logic [TAP_W-1:0] MID = TAP_W'(1) << (TAP_W - 1);

  logic [CW-1:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q    <= MID;
      busy <= 1'b0;
      bcnt <= '0;
    end else if (wr_en) begin
      q    <= wr_data;
      busy <= 1'b1;
      bcnt <= '0;
    end else if (busy && tick) begin
      if (bcnt == LAST) busy <= 1'b0;
      else              bcnt <= bcnt + 1'b1;
    end
  end
endmodule

// File: rtl/nvs_store_seq.sv
module nvs_store_seq
  import nvs_pkg::*;
#(
  parameter int TAP_W   = 4,
  parameter int DEB_MS  = 15,
  parameter int IDLE_MS = 2000,
  parameter int BUSY_MS = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1ms,
  input  logic             store_en_n,
  input  logic             btn_active,
  input  logic [TAP_W-1:0] tap_in,
  output logic             wr_valid,
  output logic [TAP_W-1:0] wr_data,
  output logic             recall_valid,
  output logic [TAP_W-1:0] recall_tap,
  output logic             freeze
);
  logic             booted;
  nvs_mode_e        mode;
  logic             pin_level, pin_rise;
  logic             idle_fire;
  logic             busy;
  logic [TAP_W-1:0] nv_q;
  logic             want_auto, want_man, trigger;

  nvs_debounce #(.DEB_TICKS(DEB_MS)) i_deb (
    .clk(clk), .rst_n(rst_n), .load(!booted), .load_val(store_en_n),
    .tick(tick_1ms), .raw(store_en_n), .level(pin_level), .rise(pin_rise)
  );

  nvs_idle_timer #(.IDLE_TICKS(IDLE_MS)) i_idle (
    .clk(clk), .rst_n(rst_n), .hold(busy || wr_valid || !booted),
    .tick(tick_1ms), .activity(btn_active), .fire(idle_fire)
  );

  nvs_cell #(.TAP_W(TAP_W), .BUSY_TICKS(BUSY_MS)) i_cell (
    .clk(clk), .rst_n(rst_n), .tick(tick_1ms), .wr_en(wr_valid),
    .wr_data(wr_data), .q(nv_q), .busy(busy)
  );

  assign want_auto = (mode == MODE_AUTO) && idle_fire && (tap_in != nv_q);
  assign want_man  = (mode == MODE_MANUAL) && pin_rise;
  assign trigger   = booted && !busy && !wr_valid && (want_auto || want_man);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      booted       <= 1'b0;
      mode         <= MODE_MANUAL;
      recall_valid <= 1'b0;
      recall_tap   <= '0;
      wr_valid     <= 1'b0;
      wr_data      <= '0;
    end else begin
      recall_valid <= 1'b0;
      wr_valid     <= trigger;
      if (trigger) wr_data <= tap_in;
      if (!booted) begin
        booted       <= 1'b1;
        mode         <= store_en_n ? MODE_MANUAL : MODE_AUTO;
        recall_valid <= 1'b1;
        recall_tap   <= nv_q;
      end
    end
  end

  assign freeze = busy || wr_valid ||
                  (booted && (mode == MODE_MANUAL) && !pin_level);
endmodule

// File: rtl/nvs_store_seq_chk.sv
module nvs_store_seq_chk #(
  parameter int TAP_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic [TAP_W-1:0] wr_data,
  input logic             recall_valid,
  input logic             freeze,
  input logic             busy,
  input logic [TAP_W-1:0] nv_q,
  input logic             mode_auto
);
  // R8
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  // R8
  wr_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> freeze);
  // R8
  wr_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !busy);
  // R4
  auto_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && mode_auto) |-> (wr_data != nv_q));
  // R2
  recall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recall_valid |=> !recall_valid);
endmodule

bind nvs_store_seq nvs_store_seq_chk #(.TAP_W(TAP_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
  .recall_valid(recall_valid), .freeze(freeze), .busy(busy),
  .nv_q(nv_q), .mode_auto(mode == nvs_pkg::MODE_AUTO)
);

// File: tb/test_nvs_store_seq.sv
module test_nvs_store_seq;
  localparam int TW = 4;
  localparam int TICK_CYC = 8;

  typedef struct packed {
    logic [3:0] tap;
    logic [7:0] low_ticks;
    logic       lock;
  } vec_t;

  localparam int ROWS = 5;
  localparam vec_t VEC [ROWS] = '{
    '{tap: 4'd5,  low_ticks: 8'd4,  lock: 1'b0},
    '{tap: 4'd6,  low_ticks: 8'd13, lock: 1'b0},
    '{tap: 4'd11, low_ticks: 8'd18, lock: 1'b1},
    '{tap: 4'd2,  low_ticks: 8'd40, lock: 1'b1},
    '{tap: 4'd9,  low_ticks: 8'd17, lock: 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1ms = 1'b0;
  logic store_en_n = 1'b1;
  logic btn_active = 1'b0;
  logic [TW-1:0] tap_in = '0;
  logic wr_valid, recall_valid, freeze;
  logic [TW-1:0] wr_data, recall_tap;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  logic [TW-1:0] last_wr = '0;
  int tcnt = 0;
  int cyc = 0;

  nvs_store_seq i_nvs_store_seq (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .store_en_n(store_en_n),
    .btn_active(btn_active), .tap_in(tap_in), .wr_valid(wr_valid),
    .wr_data(wr_data), .recall_valid(recall_valid), .recall_tap(recall_tap),
    .freeze(freeze)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tcnt <= (tcnt == TICK_CYC - 1) ? 0 : tcnt + 1;
    tick_1ms <= (tcnt == TICK_CYC - 1);
    cyc <= cyc + 1;
    if (rst_n && wr_valid) begin
      wr_cnt  <= wr_cnt + 1;
      last_wr <= wr_data;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * TICK_CYC) @(negedge clk);
  endtask

  task automatic do_reset(input logic pin);
    rst_n = 1'b0;
    store_en_n = pin;
    repeat (4) @(negedge clk);
    chk(!wr_valid && !recall_valid && !freeze, "R2 reset state", {wr_valid, recall_valid, freeze}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(recall_valid == 1'b1, "R2 recall strobe", recall_valid, 1);
    chk(recall_tap == 4'd8, "R2 recall value", recall_tap, 8);
    @(negedge clk);
    chk(recall_valid == 1'b0, "R2 recall single", recall_valid, 0);
  endtask

  initial begin
    automatic int base;
    // ---- manual mode ----
    tap_in = 4'd3;
    do_reset(1'b1);
    base = wr_cnt;
    wait_ticks(2100);
    chk(wr_cnt == base, "R1 manual no idle store", wr_cnt - base, 0);

    for (int i = 0; i < ROWS; i++) begin
      tap_in = VEC[i].tap;
      base = wr_cnt;
      store_en_n = 1'b0;
      wait_ticks(int'(VEC[i].low_ticks));
      chk(freeze == VEC[i].lock, "R7 lock while low", freeze, VEC[i].lock);
      chk(wr_cnt == base, "R6 no store while low", wr_cnt - base, 0);
      store_en_n = 1'b1;
      wait_ticks(18);
      chk(wr_cnt - base == int'(VEC[i].lock), "R6 store count", wr_cnt - base, VEC[i].lock);
      if (VEC[i].lock) begin
        chk(last_wr == VEC[i].tap, "R6 store data", last_wr, VEC[i].tap);
        chk(freeze == 1'b1, "R8 freeze in busy", freeze, 1);
      end
      wait_ticks(30);
      chk(freeze == 1'b0, "R8 freeze released", freeze, 0);
      chk(wr_cnt - base == int'(VEC[i].lock), "R8 single store", wr_cnt - base, VEC[i].lock);
    end

    // ---- automatic mode ----
    tap_in = 4'd8;
    do_reset(1'b0);
    base = wr_cnt;
    wait_ticks(2010);
    chk(wr_cnt == base, "R4 equal tap skipped", wr_cnt - base, 0);

    tap_in = 4'd12;
    btn_active = 1'b1; wait_ticks(2); btn_active = 1'b0;
    wait_ticks(1990);
    chk(wr_cnt == base, "R3 not before idle window", wr_cnt - base, 0);
    wait_ticks(20);
    chk(wr_cnt == base + 1, "R3 autostore issued", wr_cnt - base, 1);
    chk(last_wr == 4'd12, "R3 autostore data", last_wr, 12);
    chk(freeze == 1'b1, "R8 freeze during write", freeze, 1);

    tap_in = 4'd5;
    btn_active = 1'b1; wait_ticks(1); btn_active = 1'b0;
    wait_ticks(2100);
    chk(wr_cnt == base + 1, "R8 activity in busy ignored", wr_cnt - base, 1);
    chk(freeze == 1'b0, "R8 busy ends", freeze, 0);

    store_en_n = 1'b1; wait_ticks(30);
    store_en_n = 1'b0; wait_ticks(30);
    chk(freeze == 1'b0, "R9 pin no lock in auto", freeze, 0);
    chk(wr_cnt == base + 1, "R9 pin no store in auto", wr_cnt - base, 1);

    tap_in = 4'd1;
    btn_active = 1'b1; wait_ticks(1); btn_active = 1'b0;
    wait_ticks(1000);
    btn_active = 1'b1; wait_ticks(1); btn_active = 1'b0;
    wait_ticks(1500);
    chk(wr_cnt == base + 1, "R3 activity restarts count", wr_cnt - base, 1);
    wait_ticks(600);
    chk(wr_cnt == base + 2, "R3 store after restart", wr_cnt - base, 2);
    chk(last_wr == 4'd1, "R3 restart store data", last_wr, 1);
    wait_ticks(2100);
    chk(wr_cnt == base + 2, "R5 one store per idle stretch", wr_cnt - base, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc >= 190000);
    chk(1'b0, "watchdog", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule